// File: doc/BRIEF.md
# Display Address Stepper with DRAM Refresh Row Output

This block generates the graphic word address that the display refresh logic places on a multiplexed frame-buffer bus. A segment start strobe loads a 20-bit start address. After that, every display cycle moves the address forward by a step that a 3-bit mode code selects. The step can be a power of two from 1 to 16 words, zero, or one word on every second display cycle. The low 16 address bits leave on the multiplexed bus and the top 4 bits leave on a separate high-address output.

While horizontal sync is low, the block shows the value of an 8-bit DRAM refresh row counter on the bus in place of the display address. The bit field that carries the counter depends on the same mode code. Every other bus and high-address bit is driven low. The counter steps down once on every frame-buffer access strobe. Until software sets the start bit, the block keeps refresh addressing active and drives its horizontal sync output low.

Top module: `disp_addr_refresh`

## Requirements
- R1: Once reset is released with the start bit low, the bus output, the high-address output and the sync output all read 0.
- R2: With horizontal sync high and the start bit set, each display cycle (an access strobe) adds 1, 2, 4, 8 or 16 to the address for mode codes 0, 1, 2, 3 or 4. The change shows on the outputs after the clock edge that samples the strobe.
- R3: Mode code 5 leaves the display address unchanged on display cycles.
- R4: Mode codes 6 and 7 hold the address on the first display cycle after a reload, add 1 on the second, and keep alternating in that way.
- R5: The refresh counter resets to 0 and drops by 1 on every access strobe, whether the block is in display or in refresh. It wraps from 0 to 255.
- R6: During refresh output, the counter sits in bus bits [7:0] for codes 0, 5, 6 and 7, in [8:1] for code 1, in [9:2] for code 2, in [10:3] for code 3 and in [11:4] for code 4.
- R7: During refresh output, every bus bit outside the counter field reads 0 and the high-address output reads 0.
- R8: Refresh output is active when the sync input is low or the start bit is low. While the start bit is low the sync output reads 0; otherwise it follows the sync input. Access strobes during refresh do not move the display address.
- R9: A reload strobe loads the start address on the next edge and takes priority over a display-cycle step on that edge. It also restarts the alternation of R4.
- R10: The display address wraps modulo 2^20.
- R11: Outside refresh, the bus output carries address bits [15:0] and the high-address output carries bits [19:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBit | input | 1 | Start bit; low forces refresh output and low sync output |
| hsyncN | input | 1 | Horizontal sync state, active low |
| stepMode | input | 3 | Step code selecting increment and refresh field |
| startAddr | input | 20 | Segment start address |
| reload | input | 1 | Segment start strobe, loads startAddr |
| cycleStb | input | 1 | Frame-buffer access strobe, one per access |
| busOut | output | 16 | Multiplexed bus value |
| highOut | output | 4 | High four address bits |
| hsyncOutN | output | 1 | Sync output, held low until start |

## Verification
Two functions can act on the same clock edge. An access strobe can arrive together with a reload, so the reload has to win over the step. An access strobe can also arrive while sync is low, so the refresh counter has to move while the display address stays put. The bench raises reload, access strobes and low sync at random, in any combination, and adds directed cases for both collisions. After every edge it compares the bus and high-address outputs with a reference model that keeps the address, the counter and the half-rate phase.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  localparam int MODE_W  = 3;
  localparam int SHIFT_N = 5;

  typedef struct packed {
    logic       load;
    logic       advance;
    logic       refDec;
    logic       refOut;
    logic [2:0] stepSel;
    logic [2:0] shiftSel;
  } ctlStrobe_t;
endpackage

// File: rtl/disp_addr_ctrl.sv
module disp_addr_ctrl
  import disp_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBit,
  input  logic              hsyncN,
  input  logic [MODE_W-1:0] stepMode,
  input  logic              reload,
  input  logic              cycleStb,
  output ctlStrobe_t        stb,
  output logic              hsyncOutN
);
  logic refreshActive;
  logic dispCyc;
  logic halfMode;
  logic halfFlag;

  assign refreshActive = !startBit || !hsyncN;
  assign dispCyc       = cycleStb && !refreshActive;
  assign halfMode      = (stepMode[2:1] == 2'b11);
  assign hsyncOutN     = startBit ? hsyncN : 1'b0;

  always_comb begin
    stb.load     = reload;
    stb.refDec   = cycleStb;
    stb.refOut   = refreshActive;
    stb.advance  = 1'b0;
    stb.stepSel  = 3'd0;
    stb.shiftSel = 3'd0;
    case (stepMode)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: begin
        stb.advance  = dispCyc;
        stb.stepSel  = stepMode;
        stb.shiftSel = stepMode;
      end
      3'd5:    stb.advance = 1'b0;
      default: stb.advance = dispCyc && halfFlag;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        halfFlag <= 1'b0;
    else if (reload)  halfFlag <= 1'b0;
    else if (dispCyc) halfFlag <= halfMode ? ~halfFlag : 1'b0;
  end

  // R8: sync output stays low until the start bit is set
  a_r8_sync_forced: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |-> !hsyncOutN);
endmodule

// File: rtl/disp_addr_dpath.sv
module disp_addr_dpath
  import disp_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16,
  parameter int REF_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          stb,
  input  logic [ADDR_W-1:0]   loadAddr,
  output logic [BUS_W-1:0]    busOut,
  output logic [ADDR_W-BUS_W-1:0] highOut
);
  localparam int HIGH_W = ADDR_W - BUS_W;

  logic [ADDR_W-1:0] dispAddr;
  logic [ADDR_W-1:0] stepAmt;
  logic [REF_W-1:0]  refCnt;
  logic [BUS_W-1:0]  fieldVec [SHIFT_N];
  logic [BUS_W-1:0]  refBus;

  assign stepAmt = stb.advance ? (ADDR_W'(1) << stb.stepSel) : '0;

  always_ff @(posedge clk) begin
    if (!rstN)         dispAddr <= '0;
    else if (stb.load) dispAddr <= loadAddr;
    else               dispAddr <= dispAddr + stepAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           refCnt <= '0;
    else if (stb.refDec) refCnt <= refCnt - 1'b1;
  end

  for (genvar g = 0; g < SHIFT_N; g++) begin : g_field
    assign fieldVec[g] = BUS_W'(refCnt) << g;
  end

  always_comb begin
    refBus = fieldVec[0];
    for (int i = 1; i < SHIFT_N; i++)
      if (stb.shiftSel == 3'(i)) refBus = fieldVec[i];
  end

  assign busOut  = stb.refOut ? refBus : dispAddr[BUS_W-1:0];
  assign highOut = stb.refOut ? '0 : dispAddr[ADDR_W-1:BUS_W];

  // R5: counter steps down once per access
  a_r5_ref_dec: assert property (@(posedge clk) disable iff (!rstN)
    stb.refDec |=> refCnt == $past(refCnt) - 1'b1);
  // R9: reload wins over any step
  a_r9_reload: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> dispAddr == $past(loadAddr));
  // R3: no step, no reload, address unchanged
  a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.load) |=> $stable(dispAddr));
endmodule

// File: rtl/disp_addr_refresh.sv
module disp_addr_refresh
  import disp_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16,
  parameter int REF_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startBit,
  input  logic                    hsyncN,
  input  logic [2:0]              stepMode,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic                    reload,
  input  logic                    cycleStb,
  output logic [BUS_W-1:0]        busOut,
  output logic [ADDR_W-BUS_W-1:0] highOut,
  output logic                    hsyncOutN
);
  ctlStrobe_t stb;

  disp_addr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .hsyncN(hsyncN),
    .stepMode(stepMode), .reload(reload), .cycleStb(cycleStb),
    .stb(stb), .hsyncOutN(hsyncOutN)
  );

  disp_addr_dpath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .REF_W(REF_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .loadAddr(startAddr),
    .busOut(busOut), .highOut(highOut)
  );

  // R7: high bits low whenever refresh is shown
  a_r7_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!hsyncN || !startBit) |-> highOut == '0);
endmodule

// File: tb/disp_addr_refresh_test.sv
module disp_addr_refresh_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startBit = 1'b0;
  logic        hsyncN = 1'b1;
  logic [2:0]  stepMode = 3'd0;
  logic [19:0] startAddr = '0;
  logic        reload = 1'b0;
  logic        cycleStb = 1'b0;
  logic [15:0] busOut;
  logic [3:0]  highOut;
  logic        hsyncOutN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [19:0] mAddr = '0;
  logic [7:0]  mRef  = '0;
  bit          mFlag = 1'b0;

  always #10 clk = ~clk;

  disp_addr_refresh uut (
    .clk(clk), .rstN(rstN), .startBit(startBit), .hsyncN(hsyncN),
    .stepMode(stepMode), .startAddr(startAddr), .reload(reload),
    .cycleStb(cycleStb), .busOut(busOut), .highOut(highOut),
    .hsyncOutN(hsyncOutN)
  );

  function automatic int fieldShift(input logic [2:0] md);
    return (md <= 3'd4) ? int'(md) : 0;
  endfunction

  function automatic logic [15:0] expBus();
    bit refr = !startBit || !hsyncN;
    return refr ? (16'(mRef) << fieldShift(stepMode)) : mAddr[15:0];
  endfunction

  function automatic logic [3:0] expHigh();
    bit refr = !startBit || !hsyncN;
    return refr ? 4'h0 : mAddr[19:16];
  endfunction

  task automatic modelEdge();
    bit refr = !startBit || !hsyncN;
    bit disp = cycleStb && !refr;
    if (reload) begin
      mAddr = startAddr;
      mFlag = 1'b0;
    end else if (disp) begin
      if (stepMode <= 3'd4) begin
        mAddr = mAddr + (20'd1 << stepMode);
        mFlag = 1'b0;
      end else if (stepMode == 3'd5) begin
        mFlag = 1'b0;
      end else begin
        if (mFlag) mAddr = mAddr + 20'd1;
        mFlag = !mFlag;
      end
    end
    if (cycleStb) mRef = mRef - 8'd1;
  endtask

  task automatic check(input string tag);
    logic expSync = startBit ? hsyncN : 1'b0;
    nChecks++;
    if (busOut !== expBus() || highOut !== expHigh() || hsyncOutN !== expSync) begin
      nFails++;
      $display("FAIL %s: bus=%h high=%h sync=%b expected bus=%h high=%h sync=%b",
               tag, busOut, highOut, hsyncOutN, expBus(), expHigh(), expSync);
    end
  endtask

  task automatic doStep(input bit rl, input bit cy, input bit hs, input bit sb,
                        input logic [2:0] md, input logic [19:0] sa, input string tag);
    @(negedge clk);
    reload = rl; cycleStb = cy; hsyncN = hs; startBit = sb;
    stepMode = md; startAddr = sa;
    @(posedge clk);
    modelEdge();
    #2;
    check(tag);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R1 reset state");
    // R5 and R6: counter wraps to FF and sits at [11:4] for code 4
    doStep(0, 1, 1, 0, 3'd4, '0, "R5 R6 wrap and field");
    doStep(0, 1, 1, 0, 3'd1, '0, "R6 field code 1");
    // R9: load, then R10 wrap
    doStep(1, 0, 1, 1, 3'd4, 20'hFFFFF, "R9 load");
    doStep(0, 1, 1, 1, 3'd4, '0, "R10 wrap");
    doStep(0, 1, 1, 1, 3'd2, '0, "R2 step 4");
    // R4 half rate
    doStep(1, 0, 1, 1, 3'd6, 20'h12340, "R9 load half");
    doStep(0, 1, 1, 1, 3'd6, '0, "R4 hold phase");
    doStep(0, 1, 1, 1, 3'd7, '0, "R4 step phase");
    doStep(0, 1, 1, 1, 3'd6, '0, "R4 hold again");
    // R9 reload coincides with a display cycle
    doStep(1, 1, 1, 1, 3'd3, 20'hABCDE, "R9 priority");
    // R8 and R7: access during sync low, address frozen
    doStep(0, 1, 0, 1, 3'd0, '0, "R8 R7 refresh access");
    doStep(0, 0, 1, 1, 3'd0, '0, "R11 address after refresh");
    doStep(0, 1, 1, 1, 3'd5, '0, "R3 zero step");
    doStep(0, 1, 0, 1, 3'd3, '0, "R6 field code 3");
    for (int i = 0; i < 4000; i++) begin
      bit rl = ($urandom % 16) == 0;
      bit cy = ($urandom % 4) != 0;
      bit hs = ($urandom % 5) != 0;
      bit sb = ($urandom % 20) != 0;
      logic [2:0]  md = 3'($urandom % 8);
      logic [19:0] sa = 20'($urandom);
      doStep(rl, cy, hs, sb, md, sa, (!hs || !sb) ? "R6 R7 random refresh" : "R2 R11 random display");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule